// File: doc/BRIEF.md
# Memory Management Access Checker

This block sits between a 16-bit processor's operand sequencer and a paged memory manager. For every memory access it decides whether the access goes to instruction space or data space. It also decodes the three-bit access-control code of the target page and reports one of three outcomes: an abort, a management trap request, or a clean pass. Page-length checks and address relocation are handled elsewhere.

Space choice depends on how the operand was addressed. When split spaces are enabled, ordinary data operands go to data space. Operands addressed through the program counter go to data space only for the autoincrement and autoincrement-deferred forms. A read-only-with-trap code traps on reads only. Trap requests are suppressed when the target is one of the memory manager's own registers.

A 16-bit status register records the outcome. An abort latches the virtual page and the space and sets an error bit. Any set error bit freezes the register against further hardware updates until software rewrites it.

Top module: `mmu_access_chk`

## Requirements
- R1: `dspace_o` is 1 only when `split_i`=1, `fetch_i`=0 and either `reg_i` is not 7, or `reg_i`=7 with `mode_i` equal to 2 (autoincrement) or 3 (autoincrement deferred). In every other case it is 0. In particular, `reg_i`=7 with `mode_i`=1 selects instruction space.
- R2: With `req_i`=1, `abort_o` is 1 for codes 0, 3 and 7 on any access, and for codes 1 and 2 on writes (`wr_i`=1). It is 0 otherwise.
- R3: With no abort, a trap condition exists for code 1 on reads only, for code 4 on any access, and for code 5 on writes only. Codes 2 and 6 never trap, and code 1 never traps on a write.
- R4: `trap_o` requires trap enable, which is status bit 9.
- R5: `abort_o` and `trap_o` are never 1 together. An abort wins over a trap.
- R6: With `mmreg_i`=1, `trap_o` stays 0 and the status register takes no trap flag. Aborts are unaffected.
- R7: An aborting access with the status register not frozen updates the status register at the next clock edge. A non-resident abort (codes 0, 3, 7) sets bit 15 and a read-only violation sets bit 14. Bits 3:1 take `vpage_i` and bit 4 takes `dspace_o`. Other bits are unchanged.
- R8: The status register is frozen while any of bits 15, 14 or 13 is 1. While frozen, accesses leave it unchanged. A software write (`sr_wr_i`) always loads `sr_wdata_i` whole and wins over a same-cycle access.
- R9: A trap sets status bit 12 at the next edge when the register is not frozen. The bit stays set until software rewrites the register.
- R10: After reset the status register is 0. With `req_i`=0, `abort_o` and `trap_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| fetch_i | input | 1 | Instruction fetch |
| split_i | input | 1 | Separate instruction/data spaces enabled |
| mode_i | input | 3 | Addressing mode of the specifier |
| reg_i | input | 3 | Register of the specifier, 7 = program counter |
| acf_i | input | 3 | Access-control code of the page |
| mmreg_i | input | 1 | Target is a memory-management register |
| vpage_i | input | 3 | Virtual page number |
| sr_wr_i | input | 1 | Software write of the status register |
| sr_wdata_i | input | 16 | Status register write data |
| dspace_o | output | 1 | 1 = data space, 0 = instruction space |
| abort_o | output | 1 | Access aborted |
| trap_o | output | 1 | Management trap request |
| sr0_o | output | 16 | Status register |

## Verification
Space select, abort and trap are combinational, so a wrong decode shows in the same cycle as the access. A sweep over every code, direction, trap-enable and register-target case exposes it directly. A wrong status state appears one edge later in `sr0_o`. A register that fails to freeze overwrites the latched page on the very next abort, and one that freezes wrongly drops the next page number. Directed sequences place accesses right after freezing, unfreezing and same-cycle writes so that each such slip shows within one cycle.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  typedef enum logic [2:0] {
    ACF_NONRES  = 3'd0,
    ACF_RO_TRD  = 3'd1,
    ACF_RO      = 3'd2,
    ACF_RSV3    = 3'd3,
    ACF_RW_TALL = 3'd4,
    ACF_RW_TWR  = 3'd5,
    ACF_RW      = 3'd6,
    ACF_RSV7    = 3'd7
  } acf_e;

  typedef struct packed {
    logic abort_nr;
    logic abort_ro;
    logic trap;
  } acf_res_t;

  // status register bit positions
  localparam int unsigned SR_NR    = 15;
  localparam int unsigned SR_RO    = 14;
  localparam int unsigned SR_SP    = 13;
  localparam int unsigned SR_TF    = 12;
  localparam int unsigned SR_TE    = 9;
  localparam int unsigned SR_PG_LO = 1;
endpackage

// File: rtl/mmu_space_sel.sv
module mmu_space_sel #(
  parameter int unsigned REG_W  = 3,
  parameter int unsigned PC_IDX = 7
) (
  input  logic             split_i,
  input  logic             fetch_i,
  input  logic [2:0]       mode_i,
  input  logic [REG_W-1:0] reg_i,
  output logic             dspace_o
);
  localparam logic [REG_W-1:0] PC_R = REG_W'(PC_IDX);

  logic pc_sel, pc_autoinc;
  assign pc_sel     = (reg_i == PC_R);
  // R1: only autoinc / autoinc-deferred through PC reach data space
  assign pc_autoinc = (mode_i == 3'd2) || (mode_i == 3'd3);
  assign dspace_o   = split_i && !fetch_i && (!pc_sel || pc_autoinc);
endmodule

// File: rtl/mmu_acf_decode.sv
module mmu_acf_decode
  import mmu_chk_pkg::*;
(
  input  logic [2:0] acf_i,
  input  logic       wr_i,
  output acf_res_t   res_o
);
  always_comb begin
    res_o = '0;
    case (acf_i)
      ACF_NONRES, ACF_RSV3, ACF_RSV7: res_o.abort_nr = 1'b1;
      ACF_RO_TRD: begin
        res_o.abort_ro = wr_i;
        res_o.trap     = !wr_i;  // R3: read-only trap code traps on reads only
      end
      ACF_RO:      res_o.abort_ro = wr_i;
      ACF_RW_TALL: res_o.trap     = 1'b1;
      ACF_RW_TWR:  res_o.trap     = wr_i;
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/mmu_sr0_reg.sv
module mmu_sr0_reg
  import mmu_chk_pkg::*;
#(
  parameter int unsigned SR_W   = 16,
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SR_W-1:0]   wdata_i,
  input  logic              abort_nr_i,
  input  logic              abort_ro_i,
  input  logic              trap_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              dspace_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              trap_en_o
);
  localparam int unsigned SPC_POS = SR_PG_LO + PAGE_W;

  logic [SR_W-1:0] sr_q;
  logic            frozen;

  assign frozen = sr_q[SR_NR] | sr_q[SR_RO] | sr_q[SR_SP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (wr_en_i) begin
      sr_q <= wdata_i;  // R8: software write wins
    end else if (!frozen) begin
      if (abort_nr_i || abort_ro_i) begin
        sr_q[SR_NR]                   <= abort_nr_i;
        sr_q[SR_RO]                   <= abort_ro_i;
        sr_q[SPC_POS]                 <= dspace_i;
        sr_q[SPC_POS-1:SR_PG_LO]      <= page_i;
      end else if (trap_i) begin
        sr_q[SR_TF] <= 1'b1;
      end
    end
  end

  assign sr_o      = sr_q;
  assign trap_en_o = sr_q[SR_TE];
endmodule

// File: rtl/mmu_access_chk.sv
module mmu_access_chk
  import mmu_chk_pkg::*;
#(
  parameter int unsigned REG_W  = 3,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned SR_W   = 16,
  parameter int unsigned PC_IDX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              fetch_i,
  input  logic              split_i,
  input  logic [2:0]        mode_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [2:0]        acf_i,
  input  logic              mmreg_i,
  input  logic [PAGE_W-1:0] vpage_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  output logic              dspace_o,
  output logic              abort_o,
  output logic              trap_o,
  output logic [SR_W-1:0]   sr0_o
);
  acf_res_t res;
  logic     trap_en, abort_nr, abort_ro;

  mmu_space_sel #(.REG_W(REG_W), .PC_IDX(PC_IDX)) u_space (
    .split_i  (split_i),
    .fetch_i  (fetch_i),
    .mode_i   (mode_i),
    .reg_i    (reg_i),
    .dspace_o (dspace_o)
  );

  mmu_acf_decode u_acf (
    .acf_i (acf_i),
    .wr_i  (wr_i),
    .res_o (res)
  );

  assign abort_nr = req_i && res.abort_nr;
  assign abort_ro = req_i && res.abort_ro;
  assign abort_o  = abort_nr || abort_ro;
  // R5 abort first, R4 enable, R6 management-register targets never trap
  assign trap_o   = req_i && !abort_o && res.trap && trap_en && !mmreg_i;

  mmu_sr0_reg #(.SR_W(SR_W), .PAGE_W(PAGE_W)) u_sr0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (sr_wr_i),
    .wdata_i    (sr_wdata_i),
    .abort_nr_i (abort_nr),
    .abort_ro_i (abort_ro),
    .trap_i     (trap_o),
    .page_i     (vpage_i),
    .dspace_i   (dspace_o),
    .sr_o       (sr0_o),
    .trap_en_o  (trap_en)
  );
endmodule

// File: rtl/mmu_access_chk_sva.sv
module mmu_access_chk_sva #(
  parameter int unsigned REG_W  = 3,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned SR_W   = 16,
  parameter int unsigned PC_IDX = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              wr_i,
  input logic              fetch_i,
  input logic              split_i,
  input logic [2:0]        mode_i,
  input logic [REG_W-1:0]  reg_i,
  input logic [2:0]        acf_i,
  input logic              mmreg_i,
  input logic [PAGE_W-1:0] vpage_i,
  input logic              sr_wr_i,
  input logic [SR_W-1:0]   sr_wdata_i,
  input logic              dspace_o,
  input logic              abort_o,
  input logic              trap_o,
  input logic [SR_W-1:0]   sr0_o
);
  localparam logic [REG_W-1:0] PC_R = REG_W'(PC_IDX);

  logic frozen;
  assign frozen = sr0_o[15] | sr0_o[14] | sr0_o[13];

  // R1
  pc_deferred_ispace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !fetch_i && reg_i == PC_R && mode_i == 3'd1 |-> !dspace_o);
  // R1
  nosplit_ispace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (!split_i || fetch_i) |-> !dspace_o);
  // R3
  acf1_write_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && wr_i && acf_i == 3'd1 |-> !trap_o);
  // R5
  abort_trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !trap_o);
  // R6
  mmreg_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mmreg_i |-> !trap_o);
  // R7
  abort_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !frozen && !sr_wr_i |=>
      sr0_o[PAGE_W:1] == $past(vpage_i) && sr0_o[PAGE_W+1] == $past(dspace_o));
  // R8
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen && !sr_wr_i |=> $stable(sr0_o));
  // R8
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |=> sr0_o == $past(sr_wdata_i));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !abort_o && !trap_o);
endmodule

bind mmu_access_chk mmu_access_chk_sva #(
  .REG_W(REG_W), .PAGE_W(PAGE_W), .SR_W(SR_W), .PC_IDX(PC_IDX)
) u_sva (.*);

// File: tb/mmu_access_chk_bench.sv
module mmu_access_chk_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, wr_i = 0, fetch_i = 0, split_i = 0, mmreg_i = 0, sr_wr_i = 0;
  logic [2:0]  mode_i = 0, reg_i = 0, acf_i = 0, vpage_i = 0;
  logic [15:0] sr_wdata_i = 0;
  logic        dspace_o, abort_o, trap_o;
  logic [15:0] sr0_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic dsp; logic abt; logic trp; int rq; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_access_chk u_mmu_access_chk (.*);

  function automatic logic f_space(logic sp, logic fe, logic [2:0] md, logic [2:0] rg);
    return sp && !fe && (rg != 3'd7 || md == 3'd2 || md == 3'd3);
  endfunction
  function automatic logic f_abort(logic [2:0] a, logic w);
    return (a == 3'd0 || a == 3'd3 || a == 3'd7 || (w && (a == 3'd1 || a == 3'd2)));
  endfunction
  function automatic logic f_trap(logic [2:0] a, logic w, logic te, logic mm);
    return !f_abort(a, w) && te && !mm &&
           ((a == 3'd1 && !w) || a == 3'd4 || (a == 3'd5 && w));
  endfunction

  // driver: one access per cycle, expected outcome pushed to scoreboard
  task automatic drive(logic w, logic fe, logic sp, logic [2:0] md, logic [2:0] rg,
                       logic [2:0] a, logic mm, logic [2:0] pg, logic te, int rq,
                       logic swr = 0, logic [15:0] swd = 0);
    item_t it;
    @(negedge clk_i);
    req_i = 1; wr_i = w; fetch_i = fe; split_i = sp; mode_i = md; reg_i = rg;
    acf_i = a; mmreg_i = mm; vpage_i = pg; sr_wr_i = swr; sr_wdata_i = swd;
    it.dsp = f_space(sp, fe, md, rg);
    it.abt = f_abort(a, w);
    it.trp = f_trap(a, w, te, mm);
    it.rq  = rq;
    sb_q.push_back(it);
  endtask

  task automatic wr_sr(logic [15:0] v);
    @(negedge clk_i);
    req_i = 0; sr_wr_i = 1; sr_wdata_i = v;
  endtask

  task automatic check_sr(logic [15:0] exp, int rq);
    @(negedge clk_i);
    req_i = 0; sr_wr_i = 0;
    #(CLK_PERIOD/4);
    n_run++;
    if (sr0_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d status got %h exp %h", rq, sr0_o, exp);
    end
  endtask

  // monitor: pops one expected item per driven access
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (dspace_o !== it.dsp || abort_o !== it.abt || trap_o !== it.trp) begin
          n_fail++;
          $display("FAIL R%0d dsp/abt/trp got %b%b%b exp %b%b%b", it.rq,
                   dspace_o, abort_o, trap_o, it.dsp, it.abt, it.trp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*3);
    @(negedge clk_i); rst_ni = 1;
    // R10 reset state and idle outputs
    #(CLK_PERIOD/4);
    n_run++;
    if (sr0_o !== 16'h0 || abort_o !== 0 || trap_o !== 0) begin
      n_fail++;
      $display("FAIL R10 reset got %h%b%b exp 000000", sr0_o, abort_o, trap_o);
    end

    // R1 space sweep on a pass code
    for (int sp = 0; sp < 2; sp++)
      for (int fe = 0; fe < 2; fe++)
        for (int rg = 0; rg < 8; rg++)
          for (int md = 0; md < 8; md++)
            drive(0, fe[0], sp[0], md[2:0], rg[2:0], 3'd6, 0, 3'd0, 0, 1);

    // R2 R3 R4 R5 R6 code sweep, trap enable off then on
    for (int te = 0; te < 2; te++) begin
      wr_sr(te[0] ? 16'h0200 : 16'h0000);
      check_sr(te[0] ? 16'h0200 : 16'h0000, 8);
      for (int a = 0; a < 8; a++)
        for (int w = 0; w < 2; w++)
          for (int mm = 0; mm < 2; mm++)
            drive(w[0], 0, 0, 3'd1, 3'd0, a[2:0], mm[0], 3'd1, te[0],
                  f_abort(a[2:0], w[0]) ? 2 : (te[0] ? 3 : 4));
    end

    // R9 trap flag
    wr_sr(16'h0200); check_sr(16'h0200, 8);
    drive(0, 0, 0, 3'd1, 3'd0, 3'd4, 0, 3'd5, 1, 9);
    check_sr(16'h1200, 9);
    // R7 read-only violation in data space, page 3
    drive(1, 0, 1, 3'd1, 3'd0, 3'd2, 0, 3'd3, 1, 7);
    check_sr(16'h5216, 7);
    // R8 frozen: abort and trap leave status alone
    drive(0, 0, 0, 3'd1, 3'd0, 3'd0, 0, 3'd6, 1, 8);
    drive(0, 0, 0, 3'd1, 3'd0, 3'd4, 0, 3'd6, 1, 8);
    check_sr(16'h5216, 8);
    // R8 write wins over same-cycle abort
    drive(0, 0, 0, 3'd1, 3'd0, 3'd0, 0, 3'd6, 1, 8, 1, 16'h0000);
    check_sr(16'h0000, 8);
    // R8 spare error bit freezes
    wr_sr(16'h2000); check_sr(16'h2000, 8);
    drive(0, 0, 0, 3'd1, 3'd0, 3'd0, 0, 3'd5, 0, 8);
    check_sr(16'h2000, 8);
    // R7 non-resident abort on fetch, page 7, instruction space
    wr_sr(16'h0000); check_sr(16'h0000, 8);
    drive(0, 1, 1, 3'd2, 3'd7, 3'd0, 0, 3'd7, 0, 7);
    check_sr(16'h800E, 7);
    // R6 management register target: no trap, no flag; abort still latched
    wr_sr(16'h0200); check_sr(16'h0200, 8);
    drive(0, 0, 0, 3'd1, 3'd0, 3'd4, 1, 3'd4, 1, 6);
    check_sr(16'h0200, 6);
    drive(0, 0, 0, 3'd1, 3'd0, 3'd0, 1, 3'd2, 1, 6);
    check_sr(16'h8204, 6);

    done = 1;
    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule